// File: doc/BRIEF.md
# Reset-Qualified Start Address Fetcher

This block turns a raw, active-low reset pin into an orderly processor start-up. The pin is brought into the clock domain by a two-flop synchroniser. A counter then measures how long the synchronised level stays low. A reset is recognised only after ten consecutive low clocks; any shorter dip is treated as noise and has no effect at all.

Once a reset is recognised, several processor state values are forced at once: the system stack pointer goes to 0x000100, the 3-bit interrupt mask goes to all ones, the maximum-mode bit goes to 1, and the 3-bit bank pointer goes to zero. The program counter is not forced, and nothing else is touched either.

When the pin returns high, the block reads three bytes, one at a time, through a byte-read port with a valid strobe. It builds the 24-bit start address little-endian from these bytes, loads it into the program counter, and raises the run flag one clock later.

Top module: `rst_vector_seq`

## Requirements
- R1: The raw reset passes through two flops. A reset is accepted on the clock edge at which the synchronised level has been sampled low for MIN_LOW (10) consecutive edges. With the pin falling just before edge 1, run is still at its earlier value after edge 11 and is 0 after edge 12.
- R2: At acceptance, and for as long as the reset is held, the outputs are as follows: stack pointer = 0x000100, interrupt mask = 3'b111, maximum-mode bit = 1, bank select = 3'b000, run = 0 and rd_req = 0.
- R3: Accepting a reset leaves the program counter unchanged. The program counter changes only when a fetched byte is captured.
- R4: After the synchronised level returns high, the block reads 0xFFFF00, then 0xFFFF01, then 0xFFFF02. It holds rd_req high with a stable rd_addr until a cycle in which rd_valid is high; rd_data is captured in that cycle.
- R5: After the fetch, the program counter holds byte(0xFFFF02) in bits 23:16, byte(0xFFFF01) in bits 15:8 and byte(0xFFFF00) in bits 7:0.
- R6: run is still 0 in the cycle after the edge that captures the third byte, and it is 1 one clock later.
- R7: A low pulse shorter than 10 synchronised clocks is ignored: it causes no read request, and it leaves run, the program counter and all forced values unchanged.
- R8: A reset accepted while a fetch is in progress abandons that fetch. After release, a new fetch starts again at 0xFFFF00.
- R9: Before any reset has been accepted, run and rd_req are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n_raw | input | 1 | Raw active-low reset pin, asynchronous |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 24 | Byte read address |
| rd_data | input | 8 | Byte read data |
| rd_valid | input | 1 | rd_data is valid this cycle |
| pc | output | 24 | Program counter |
| sp | output | 24 | System stack pointer |
| int_mask | output | 3 | Interrupt mask level |
| max_mode | output | 1 | Maximum-mode status bit |
| bank_sel | output | 3 | Register bank pointer |
| run | output | 1 | Execution may start |

## Verification
The hardest situation to reach from the ports is a second reset that arrives in the middle of a fetch. It must land after one byte has already changed the program counter but before the next byte is answered. The bench gets there by slowing its memory responder to a 20-cycle latency. It waits until exactly one byte has been delivered, then holds the pin low for twelve clocks, which is still inside the responder's wait. It then checks that the restarted fetch begins again at the lowest address and assembles the start address from fresh data. The pulse-length threshold is swept over every width from 1 to 14 clocks, both before the first start-up and while running.

// File: rtl/rst_vector_seq.sv
module rst_vector_seq #(
  parameter int          MIN_LOW  = 10,
  parameter logic [23:0] VEC_BASE = 24'hFFFF00,
  parameter logic [23:0] SP_INIT  = 24'h000100
) (
  input  logic        clk,
  input  logic        rst_n_raw,
  output logic        rd_req,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  input  logic        rd_valid,
  output logic [23:0] pc,
  output logic [23:0] sp,
  output logic [2:0]  int_mask,
  output logic        max_mode,
  output logic [2:0]  bank_sel,
  output logic        run
);
  localparam int CW = $clog2(MIN_LOW + 1);

  typedef enum logic [2:0] {ST_OFF, ST_HOLD, ST_B0, ST_B1, ST_B2, ST_GO, ST_RUN} st_t;

  logic [1:0]    sync   = 2'b11;
  logic [CW-1:0] lowcnt = '0;
  st_t           st     = ST_OFF;
  logic [23:0]   pc_q   = '0;
  logic [23:0]   sp_q   = '0;
  logic [2:0]    mask_q = '0;
  logic          max_q  = 1'b0;
  logic [2:0]    bank_q = '0;
  logic [1:0]    idx;
  logic          low, accept;

  assign low    = ~sync[1];
  assign accept = low && (lowcnt == CW'(MIN_LOW - 1));

  always_comb begin
    case (st)
      ST_B1:   idx = 2'd1;
      ST_B2:   idx = 2'd2;
      default: idx = 2'd0;
    endcase
  end

  assign rd_req   = (st == ST_B0) || (st == ST_B1) || (st == ST_B2);
  assign rd_addr  = VEC_BASE + {22'd0, idx};
  assign run      = (st == ST_RUN);
  assign pc       = pc_q;
  assign sp       = sp_q;
  assign int_mask = mask_q;
  assign max_mode = max_q;
  assign bank_sel = bank_q;

  always_ff @(posedge clk) begin
    sync <= {sync[0], rst_n_raw};
    if (!low)
      lowcnt <= '0;
    else if (lowcnt != CW'(MIN_LOW))
      lowcnt <= lowcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      st     <= ST_HOLD;
      sp_q   <= SP_INIT;
      mask_q <= 3'b111;
      max_q  <= 1'b1;
      bank_q <= 3'b000;
    end else begin
      case (st)
        ST_HOLD: if (!low) st <= ST_B0;
        ST_B0:   if (rd_valid) st <= ST_B1;
        ST_B1:   if (rd_valid) st <= ST_B2;
        ST_B2:   if (rd_valid) st <= ST_GO;
        ST_GO:   st <= ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!accept && rd_req && rd_valid) begin
      case (idx)
        2'd0:    pc_q[7:0]   <= rd_data;
        2'd1:    pc_q[15:8]  <= rd_data;
        default: pc_q[23:16] <= rd_data;
      endcase
    end
  end
endmodule

// File: rtl/rst_vector_seq_chk.sv
module rst_vector_seq_chk #(
  parameter logic [23:0] VEC_BASE = 24'hFFFF00,
  parameter logic [23:0] SP_INIT  = 24'h000100
) (
  input logic        clk,
  input logic        rst_n_raw,
  input logic        rd_req,
  input logic [23:0] rd_addr,
  input logic        rd_valid,
  input logic [23:0] pc,
  input logic [23:0] sp,
  input logic [2:0]  int_mask,
  input logic        max_mode,
  input logic [2:0]  bank_sel,
  input logic        run
);
  logic up = 1'b0;
  always_ff @(posedge clk) up <= 1'b1;

  assert_fall_needs_low_R1: assert property (@(posedge clk) disable iff (!up)
    $fell(run) |-> !$past(rst_n_raw, 3));

  assert_forced_values_R2: assert property (@(posedge clk) disable iff (!up)
    $fell(run) |-> (sp == SP_INIT && int_mask == 3'b111 && max_mode && bank_sel == 3'b000));

  assert_pc_only_on_beat_R3: assert property (@(posedge clk) disable iff (!up)
    !(rd_req && rd_valid) |=> $stable(pc));

  assert_addr_in_window_R4: assert property (@(posedge clk) disable iff (!up)
    rd_req |-> (rd_addr[23:2] == VEC_BASE[23:2] && rd_addr[1:0] != 2'd3));

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!up)
    (rd_req && !rd_valid) |=> (!rd_req || $stable(rd_addr)));

  assert_run_after_last_R6: assert property (@(posedge clk) disable iff (!up)
    $rose(run) |-> $past(rd_req && rd_valid && rd_addr[1:0] == 2'd2, 2));

  assert_no_req_when_run_R7: assert property (@(posedge clk) disable iff (!up)
    run |-> !rd_req);
endmodule

bind rst_vector_seq rst_vector_seq_chk #(.VEC_BASE(VEC_BASE), .SP_INIT(SP_INIT)) u_chk (
  .clk(clk), .rst_n_raw(rst_n_raw), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .pc(pc), .sp(sp), .int_mask(int_mask),
  .max_mode(max_mode), .bank_sel(bank_sel), .run(run));

// File: tb/rst_vector_seq_test.sv
`timescale 1ns/1ps
module rst_vector_seq_test;
  localparam logic [23:0] VEC = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        rst_n_raw = 1'b1;
  logic        rd_req, rd_valid = 1'b0;
  logic [23:0] rd_addr, pc, sp;
  logic [7:0]  rd_data = 8'h00;
  logic [2:0]  int_mask, bank_sel;
  logic        max_mode, run;

  int   errors = 0, checks = 0, delay = 0, wcnt = 0, idx_exp = 0, post = 0, cyc = 0;
  bit   saw_req = 0;
  logic [7:0] seed = 8'h00;

  always #5 clk = ~clk;

  rst_vector_seq uut (
    .clk(clk), .rst_n_raw(rst_n_raw), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .pc(pc), .sp(sp),
    .int_mask(int_mask), .max_mode(max_mode), .bank_sel(bank_sel), .run(run));

  function automatic logic [7:0] vb(input logic [7:0] s, input logic [1:0] a);
    return s * 8'd7 + {6'd0, a} * 8'h35 + 8'h11;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
    rd_valid = 1'b0;
    if (post == 1) begin chk(run == 1'b0, "R6 run low after capture", run, 0); post = 2; end
    else if (post == 2) begin chk(run == 1'b1, "R6 run high one clock later", run, 1); post = 0; end
    if (rd_req) begin
      saw_req = 1;
      if (wcnt >= delay) begin
        rd_valid = 1'b1;
        rd_data  = vb(seed, rd_addr[1:0]);
        chk(rd_addr == VEC + 24'(idx_exp), "R4 read order", rd_addr, VEC + 24'(idx_exp));
        idx_exp++;
        wcnt = 0;
        if (rd_addr[1:0] == 2'd2) post = 1;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic wait_run();
    for (int t = 0; t < 400 && !run; t++) @(negedge clk);
    chk(run == 1'b1, "R6 run reached", run, 1);
    if (!run) finish_run();
  endtask

  task automatic pulse(input int n);
    logic [23:0] pc0 = pc, sp0 = sp;
    logic [2:0]  m0 = int_mask, b0 = bank_sel;
    logic        x0 = max_mode, r0 = run;
    int last = (n > 12) ? n : 12;
    saw_req = 0;
    idx_exp = 0;
    rst_n_raw = 1'b0;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == n) rst_n_raw = 1'b1;
      if (k == 11) chk(run == r0, "R1 not yet accepted at edge 11", run, r0);
      if (k == 12 && n >= 10) begin
        chk(run == 1'b0, "R1 accepted at edge 12", run, 0);
        chk(sp == 24'h000100, "R2 stack pointer", sp, 24'h000100);
        chk(int_mask == 3'b111 && max_mode && bank_sel == 3'b000, "R2 mask/mode/bank",
            {int_mask, max_mode, bank_sel}, {3'b111, 1'b1, 3'b000});
        chk(rd_req == 1'b0, "R2 no request while held", rd_req, 0);
        chk(pc == pc0, "R3 pc kept on accept", pc, pc0);
      end
    end
    if (n < 10) begin
      repeat (10) @(negedge clk);
      chk(!saw_req, "R7 no fetch on short pulse", saw_req, 0);
      chk(run == r0 && pc == pc0 && sp == sp0, "R7 state unchanged", {run, pc}, {r0, pc0});
      chk(int_mask == m0 && bank_sel == b0 && max_mode == x0, "R7 fields unchanged",
          {int_mask, bank_sel, max_mode}, {m0, b0, x0});
    end else begin
      wait_run();
      chk(pc == {vb(seed, 2), vb(seed, 1), vb(seed, 0)}, "R5 pc assembled", pc,
          {vb(seed, 2), vb(seed, 1), vb(seed, 0)});
      chk(idx_exp == 3, "R4 three reads", idx_exp, 3);
    end
  endtask

  initial begin
    repeat (6) @(negedge clk);
    chk(run == 1'b0, "R9 run low before reset", run, 0);
    chk(rd_req == 1'b0, "R9 no request before reset", rd_req, 0);
    for (int n = 1; n <= 14; n++) begin
      delay = n % 4;
      seed  = 8'(n * 13);
      pulse(n);
    end
    for (int n = 1; n <= 9; n++) pulse(n);
    for (int d = 0; d <= 5; d++) begin
      delay = d;
      seed  = 8'(d * 29 + 3);
      pulse(10);
    end
    // R8: second reset in the middle of a fetch
    delay = 20;
    seed  = 8'hA5;
    idx_exp = 0;
    rst_n_raw = 1'b0;
    repeat (12) @(negedge clk);
    rst_n_raw = 1'b1;
    for (int t = 0; t < 200 && idx_exp < 1; t++) @(negedge clk);
    chk(idx_exp == 1 && run == 1'b0, "R8 one byte delivered", idx_exp, 1);
    seed = 8'h3C;
    idx_exp = 0;
    rst_n_raw = 1'b0;
    repeat (12) @(negedge clk);
    rst_n_raw = 1'b1;
    chk(rd_req == 1'b0 && idx_exp == 0, "R8 fetch abandoned", {rd_req, 8'(idx_exp)}, 0);
    wait_run();
    chk(idx_exp == 3, "R8 restart read count", idx_exp, 3);
    chk(pc == {vb(seed, 2), vb(seed, 1), vb(seed, 0)}, "R8 pc from restarted fetch", pc,
        {vb(seed, 2), vb(seed, 1), vb(seed, 0)});
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule